// File: doc/BRIEF.md
# Banked Predicate Register File

This block stores the one-bit predicates that qualify instructions in a subword-parallel datapath. By default it holds 16 banks of 8 predicates, 128 bits in all. A bank-select register picks which bank is visible. Instructions then name a predicate with a 3-bit index into that bank. Index 0 is wired to read as true, so an instruction that names it always executes.

Compare units report their results on several compare write ports that all act in the same cycle. A normal compare writes the relation result to its true-destination and the complement to its false-destination. A parallel-write-one compare writes only when its relation holds: 1 to the true-destination and 0 to the false-destination. When it does not hold, nothing changes.

Several parallel-write-one compares can target the same predicates in one cycle and are merged in that cycle. When a predicate receives both a 1 and a 0 in one cycle, the 1 wins. Reads are combinational from the registered state, through a parameterised number of read ports.

Top module: `pred_regfile`

## Requirements
- R1: After reset every predicate of every bank holds 0, and bank 0 is the active bank.
- R2: Index 0 reads as 1 on every read port in every bank. Compare writes aimed at index 0 leave it reading 1.
- R3: A compare with kind bit 0 (normal) and valid 1 sets its true-destination to the relation bit and its false-destination to the complement of that bit. Compare c takes its relation from cmp_rel[c], its kind from cmp_kind[c], its true-destination from cmp_dst_t[3c+2:3c] and its false-destination from cmp_dst_f[3c+2:3c].
- R4: A compare with kind bit 1 (parallel-write-one) and valid 1 writes 1 to its true-destination and 0 to its false-destination when the relation bit is 1. When the relation bit is 0 it changes no predicate.
- R5: All compare ports act in the same cycle. A predicate that receives a 1 from any port and a 0 from any other port (or from the same port) in that cycle becomes 1.
- R6: Compare writes change only the bank that is active in the cycle of the write. Every other bank keeps its contents.
- R7: A value written through the bank-select port becomes the active bank for reads and writes from the next cycle. A compare issued in the same cycle as a bank-select write lands in the previously active bank.
- R8: Read port r returns the predicate of the active bank named by rd_idx[3r+2:3r]. The read ports work independently, including when two ports read the same index.
- R9: A compare port with valid 0 has no effect, whatever its other fields hold.
- R10: A compare write becomes visible on the read ports in the cycle after it is issued. In the cycle it is issued, reads return the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_we | input | 1 | Bank-select write strobe |
| bank_wdata | input | BANK_W (4) | New active bank number |
| cmp_valid | input | NUM_CMP (4) | Per-port compare write valid |
| cmp_kind | input | NUM_CMP (4) | Per-port kind: 0 normal, 1 parallel-write-one |
| cmp_rel | input | NUM_CMP (4) | Per-port relation result |
| cmp_dst_t | input | NUM_CMP*3 (12) | Per-port true-destination index, 3 bits each |
| cmp_dst_f | input | NUM_CMP*3 (12) | Per-port false-destination index, 3 bits each |
| rd_idx | input | NUM_RD*3 (6) | Per-port read index, 3 bits each |
| rd_val | output | NUM_RD (2) | Per-port predicate value |

## Verification
The bench builds the file with 4 banks of 8 predicates, 3 compare ports and 2 read ports. With 4 banks, every bank can be swept. It also allows every combination of port, kind, relation, true-destination and false-destination for a single compare, and each result is read back through all eight indices. With 3 compare ports, pseudo-random multi-port patterns cause set/clear collisions on shared predicates often. The bank-select edge and the no-bypass read timing are probed both just before and just after the clock edge.

// File: rtl/pred_rf_pkg.sv
package pred_rf_pkg;

    // Encoding of the per-port compare kind bit.
    typedef enum logic {
        CMP_NORMAL = 1'b0,
        CMP_PW1    = 1'b1
    } cmp_kind_e;

endpackage

// File: rtl/pred_cmp_decode.sv
module pred_cmp_decode
    import pred_rf_pkg::*;
#(
    parameter int unsigned NPRED = 8,
    localparam int unsigned IDX_W = $clog2(NPRED)
) (
    input  logic             valid,
    input  logic             kind,
    input  logic             rel,
    input  logic [IDX_W-1:0] dst_t,
    input  logic [IDX_W-1:0] dst_f,
    output logic [NPRED-1:0] set_mask,
    output logic [NPRED-1:0] clr_mask
);

    cmp_kind_e kind_e;
    assign kind_e = cmp_kind_e'(kind);

    // Translate one compare result into predicates to force high or low.
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (valid) begin
            unique case (kind_e)
                CMP_PW1: begin
                    if (rel) begin
                        set_mask[dst_t] = 1'b1;
                        clr_mask[dst_f] = 1'b1;
                    end
                end
                default: begin
                    if (rel) set_mask[dst_t] = 1'b1;
                    else     clr_mask[dst_t] = 1'b1;
                    if (rel) clr_mask[dst_f] = 1'b1;
                    else     set_mask[dst_f] = 1'b1;
                end
            endcase
        end
    end

    // An idle port produces no update at all.
    always_comb begin
        if (!valid) begin
            p_idle_no_masks_r9: assert ((set_mask | clr_mask) == '0);
        end
    end

    // A failing parallel-write-one compare leaves every predicate alone.
    always_comb begin
        if (valid && kind_e == CMP_PW1 && !rel) begin
            p_pw1_false_hold_r4: assert ((set_mask | clr_mask) == '0);
        end
    end

endmodule

// File: rtl/pred_merge.sv
module pred_merge #(
    parameter int unsigned NPRED = 8,
    parameter int unsigned NCMP  = 4
) (
    input  logic [NPRED-1:0]           row_q,
    input  logic [NCMP-1:0][NPRED-1:0] set_masks,
    input  logic [NCMP-1:0][NPRED-1:0] clr_masks,
    output logic [NPRED-1:0]           row_d
);

    logic [NPRED-1:0] any_set;
    logic [NPRED-1:0] any_clr;

    // Collapse all ports into a single set and clear vector.
    always_comb begin
        any_set = '0;
        any_clr = '0;
        for (int c = 0; c < NCMP; c++) begin
            any_set = any_set | set_masks[c];
            any_clr = any_clr | clr_masks[c];
        end
    end

    // Clear first, then set: a 1 from any port overrides a 0.
    // Slot 0 is never stored; it reads as a constant 1.
    always_comb begin
        row_d    = (row_q & ~any_clr) | any_set;
        row_d[0] = 1'b0;
    end

    for (genvar i = 1; i < NPRED; i++) begin : g_chk
        always_comb begin
            if (any_set[i]) begin
                p_set_wins_r5: assert (row_d[i]);
            end
        end
    end

endmodule

// File: rtl/pred_read_mux.sv
module pred_read_mux #(
    parameter int unsigned NBANK = 16,
    parameter int unsigned NPRED = 8,
    localparam int unsigned BANK_W = $clog2(NBANK),
    localparam int unsigned IDX_W  = $clog2(NPRED)
) (
    input  logic [NBANK*NPRED-1:0] preds,
    input  logic [BANK_W-1:0]      bank,
    input  logic [IDX_W-1:0]       idx,
    output logic                   val
);

    // Index 0 is hard-wired true; all others come from the active bank.
    always_comb begin
        if (idx == '0) val = 1'b1;
        else           val = preds[{bank, idx}];
    end

endmodule

// File: rtl/pred_regfile.sv
module pred_regfile
    import pred_rf_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 16,
    parameter int unsigned NPRED     = 8,
    parameter int unsigned NUM_CMP   = 4,
    parameter int unsigned NUM_RD    = 2,
    localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
    localparam int unsigned IDX_W    = $clog2(NPRED)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bank_we,
    input  logic [BANK_W-1:0]         bank_wdata,
    input  logic [NUM_CMP-1:0]        cmp_valid,
    input  logic [NUM_CMP-1:0]        cmp_kind,
    input  logic [NUM_CMP-1:0]        cmp_rel,
    input  logic [NUM_CMP*IDX_W-1:0]  cmp_dst_t,
    input  logic [NUM_CMP*IDX_W-1:0]  cmp_dst_f,
    input  logic [NUM_RD*IDX_W-1:0]   rd_idx,
    output logic [NUM_RD-1:0]         rd_val
);

    typedef struct packed {
        logic [BANK_W-1:0]                 bank;
        logic [NUM_BANKS-1:0][NPRED-1:0]   pred;
    } rf_state_t;

    rf_state_t state_d, state_q;

    logic [NUM_CMP-1:0][NPRED-1:0] set_m;
    logic [NUM_CMP-1:0][NPRED-1:0] clr_m;
    logic [NPRED-1:0]              row_q;
    logic [NPRED-1:0]              row_d;
    logic [NUM_BANKS*NPRED-1:0]    pred_flat;

    // One decoder per compare write port.
    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        pred_cmp_decode #(.NPRED(NPRED)) i_dec (
            .valid    (cmp_valid[c]),
            .kind     (cmp_kind[c]),
            .rel      (cmp_rel[c]),
            .dst_t    (cmp_dst_t[c*IDX_W +: IDX_W]),
            .dst_f    (cmp_dst_f[c*IDX_W +: IDX_W]),
            .set_mask (set_m[c]),
            .clr_mask (clr_m[c])
        );
    end

    assign row_q = state_q.pred[state_q.bank];

    pred_merge #(.NPRED(NPRED), .NCMP(NUM_CMP)) i_merge (
        .row_q     (row_q),
        .set_masks (set_m),
        .clr_masks (clr_m),
        .row_d     (row_d)
    );

    // Next state: merged row goes back into the bank active now;
    // a bank-select write takes over from the next cycle.
    always_comb begin
        state_d = state_q;
        state_d.pred[state_q.bank] = row_d;
        if (bank_we) state_d.bank = bank_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign pred_flat = state_q.pred;

    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        pred_read_mux #(.NBANK(NUM_BANKS), .NPRED(NPRED)) i_rd (
            .preds (pred_flat),
            .bank  (state_q.bank),
            .idx   (rd_idx[r*IDX_W +: IDX_W]),
            .val   (rd_val[r])
        );

        p_idx0_true_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_idx[r*IDX_W +: IDX_W] == '0) |-> rd_val[r]);
    end

    p_bank_switch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |=> (state_q.bank == $past(bank_wdata)));

    p_idle_ports_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid == '0) |=> $stable(state_q.pred));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
        p_idle_bank_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q.bank != BANK_W'(b)) |=> $stable(state_q.pred[b]));
    end

endmodule

// File: tb/test_pred_regfile.sv
module test_pred_regfile;

    localparam int NB = 4;
    localparam int NP = 8;
    localparam int NC = 3;
    localparam int NR = 2;
    localparam int IW = 3;
    localparam int BW = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            bank_we;
    logic [BW-1:0]   bank_wdata;
    logic [NC-1:0]   cmp_valid;
    logic [NC-1:0]   cmp_kind;
    logic [NC-1:0]   cmp_rel;
    logic [NC*IW-1:0] cmp_dst_t;
    logic [NC*IW-1:0] cmp_dst_f;
    logic [NR*IW-1:0] rd_idx;
    logic [NR-1:0]   rd_val;

    pred_regfile #(.NUM_BANKS(NB), .NPRED(NP), .NUM_CMP(NC), .NUM_RD(NR)) i_pred_regfile (
        .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_wdata(bank_wdata),
        .cmp_valid(cmp_valid), .cmp_kind(cmp_kind), .cmp_rel(cmp_rel),
        .cmp_dst_t(cmp_dst_t), .cmp_dst_f(cmp_dst_f),
        .rd_idx(rd_idx), .rd_val(rd_val)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic [NP-1:0] m_pred [NB];
    int m_bank;
    logic [31:0] lf = 32'h1ACE_B00C;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lf = lf ^ (lf << 13);
        lf = lf ^ (lf >> 17);
        lf = lf ^ (lf << 5);
        return lf;
    endfunction

    // Expected effect of the driven inputs on the reference model.
    task automatic model_step();
        logic [NP-1:0] s, c;
        s = '0; c = '0;
        for (int k = 0; k < NC; k++) begin
            if (cmp_valid[k]) begin
                int t, f;
                t = cmp_dst_t[k*IW +: IW];
                f = cmp_dst_f[k*IW +: IW];
                if (cmp_kind[k]) begin
                    if (cmp_rel[k]) begin s[t] = 1'b1; c[f] = 1'b1; end
                end else begin
                    if (cmp_rel[k]) begin s[t] = 1'b1; c[f] = 1'b1; end
                    else            begin c[t] = 1'b1; s[f] = 1'b1; end
                end
            end
        end
        for (int i = 1; i < NP; i++) begin
            if (s[i])      m_pred[m_bank][i] = 1'b1;
            else if (c[i]) m_pred[m_bank][i] = 1'b0;
        end
        if (bank_we) m_bank = int'(bank_wdata);
    endtask

    task automatic idle_inputs();
        bank_we = 0; bank_wdata = '0;
        cmp_valid = '0; cmp_kind = '0; cmp_rel = '0;
        cmp_dst_t = '0; cmp_dst_f = '0;
    endtask

    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic check_bank(string req);
        for (int i = 0; i < NP / NR; i++) begin
            rd_idx = {IW'(2*i+1), IW'(2*i)};
            #1;
            for (int p = 0; p < NR; p++) begin
                int idx;
                idx = 2*i + p;
                check(req, rd_val[p], (idx == 0) ? 1 : int'(m_pred[m_bank][idx]));
            end
        end
    endtask

    task automatic select_bank(int b);
        bank_we = 1; bank_wdata = BW'(b);
        cycle();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        for (int b = 0; b < NB; b++) m_pred[b] = '0;
        m_bank = 0;
        idle_inputs();
        rd_idx = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset contents, bank 0 active; R2: index 0 true
        check_bank("R1");
        for (int b = 0; b < NB; b++) begin
            select_bank(b);
            check_bank("R1");
        end
        select_bank(0);

        // R2: writes aimed at index 0 are ignored
        for (int b = 0; b < NB; b++) begin
            select_bank(b);
            for (int rl = 0; rl < 2; rl++) begin
                cmp_valid = 3'b111; cmp_kind = 3'b000; cmp_rel = rl[0] ? 3'b111 : 3'b000;
                cmp_dst_t = '0; cmp_dst_f = '0;
                cycle();
                rd_idx = '0; #1;
                check("R2", rd_val[0], 1);
                check("R2", rd_val[1], 1);
            end
        end

        // R3/R4: exhaustive single-port sweep in every bank
        for (int b = 0; b < NB; b++) begin
            select_bank(b);
            for (int c = 0; c < NC; c++)
                for (int k = 0; k < 2; k++)
                    for (int rl = 0; rl < 2; rl++)
                        for (int t = 0; t < NP; t++)
                            for (int f = 0; f < NP; f++) begin
                                cmp_valid = '0; cmp_valid[c] = 1'b1;
                                cmp_kind[c] = k[0];
                                cmp_rel[c] = rl[0];
                                cmp_dst_t[c*IW +: IW] = IW'(t);
                                cmp_dst_f[c*IW +: IW] = IW'(f);
                                cycle();
                                check_bank(k == 1 ? "R4" : "R3");
                            end
        end

        // R6: every bank against the model after the sweep
        for (int b = 0; b < NB; b++) begin
            select_bank(b);
            check_bank("R6");
        end

        // R5: multi-port collisions
        for (int n = 0; n < 600; n++) begin
            logic [31:0] r;
            if (n % 150 == 0) select_bank(n / 150);
            r = rnd();
            cmp_valid = 3'b111;
            cmp_kind  = r[2:0];
            cmp_rel   = r[5:3];
            cmp_dst_t = r[14:6];
            cmp_dst_f = r[23:15];
            cycle();
            check_bank("R5");
        end

        // R9: idle ports with busy fields
        for (int n = 0; n < 40; n++) begin
            logic [31:0] r;
            r = rnd();
            cmp_valid = '0;
            cmp_kind  = r[2:0];
            cmp_rel   = r[5:3];
            cmp_dst_t = r[14:6];
            cmp_dst_f = r[23:15];
            cycle();
            check_bank("R9");
        end

        // R10: no bypass of a write in its own cycle
        select_bank(1);
        cmp_valid = 3'b001; cmp_kind = 3'b000; cmp_rel = 3'b000;
        cmp_dst_t[2:0] = 3'd5; cmp_dst_f[2:0] = 3'd6;
        cycle();
        cmp_valid = 3'b001; cmp_kind = 3'b000; cmp_rel = 3'b001;
        cmp_dst_t[2:0] = 3'd5; cmp_dst_f[2:0] = 3'd6;
        rd_idx = {3'd6, 3'd5}; #1;
        check("R10", rd_val[0], 0);
        check("R10", rd_val[1], 1);
        cycle();
        rd_idx = {3'd6, 3'd5}; #1;
        check("R10", rd_val[0], 1);
        check("R10", rd_val[1], 0);

        // R7: bank switch with a same-cycle compare
        cmp_valid = 3'b010; cmp_kind = 3'b000; cmp_rel = 3'b010;
        cmp_dst_t[5:3] = 3'd3; cmp_dst_f[5:3] = 3'd4;
        bank_we = 1; bank_wdata = 2'd2;
        rd_idx = {3'd4, 3'd3}; #1;
        check("R7", rd_val[0], int'(m_pred[1][3]));
        check("R7", rd_val[1], int'(m_pred[1][4]));
        cycle();
        check_bank("R7");
        select_bank(1);
        rd_idx = {3'd4, 3'd3}; #1;
        check("R7", rd_val[0], 1);
        check("R7", rd_val[1], 0);

        // R8: every pair of indices on the two ports
        for (int a = 0; a < NP; a++)
            for (int b = 0; b < NP; b++) begin
                rd_idx = {IW'(b), IW'(a)}; #1;
                check("R8", rd_val[0], (a == 0) ? 1 : int'(m_pred[m_bank][a]));
                check("R8", rd_val[1], (b == 0) ? 1 : int'(m_pred[m_bank][b]));
            end

        done = 1;
        finish_run();
    end

endmodule